// File: doc/BRIEF.md
# DRAM Row/Column/Refresh Address Multiplexer

This block folds a 12-bit system address onto the 6 multiplexed address lines of a dynamic RAM array that needs 64 refresh rows. Two select inputs choose the source. When refresh is selected, the lines carry an internal 6-bit refresh counter. Otherwise the row-select level picks either the low half of the address (row) or the high half (column). Every output bit is the inverse of the bit it carries.

The refresh counter moves forward by one for each active-low pulse on a count strobe. The strobe is brought into the system clock domain, and the counter steps at the end of each pulse. An active-low output enable and an active-low power-good input can switch the address lines off. When power-good is low, the counter is also forced to all ones, so refresh resumes from a known row once power returns. The address path is purely combinational, and only the counter and the strobe synchronizer hold state.

Top module: `dram_addr_mux`

## Requirements
- R1: With refresh select low and row select high, `addr_o` equals the bitwise inverse of `addr_i[5:0]` in the same cycle, with no clock edge needed.
- R2: With refresh select and row select both low, `addr_o` equals the bitwise inverse of `addr_i[11:6]`.
- R3: With refresh select high, `addr_o` equals the bitwise inverse of the refresh counter. The address halves and the row select have no effect.
- R4: Outputs follow changes on `addr_i`, `row_en_i` and `refresh_en_i` combinationally, and every source is presented inverted.
- R5: Each low pulse on `count_n_i` advances the counter by exactly one. The step happens at the low-to-high transition and is visible within 3 clock edges after it. While the strobe is held low, the counter does not change.
- R6: The counter wraps from 63 to 0, and it advances whether or not refresh is selected.
- R7: While `oe_n_i` is high, `drive_en_o` is all zeros and `addr_o` is high-impedance, whatever the other inputs are.
- R8: While `pwr_good_i` is low, the outputs are disabled, count pulses are ignored, and the counter is loaded with 6'b111111. When power-good returns, refresh addressing resumes from 63.
- R9: Synchronous reset `rst` sets the counter to all ones (63) and returns the strobe synchronizer to its idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | System address; bits 5:0 are the row half, bits 11:6 the column half |
| refresh_en_i | input | 1 | High selects the refresh counter as the source |
| row_en_i | input | 1 | High selects the row half, low the column half, when refresh is off |
| count_n_i | input | 1 | Active-low count strobe; each pulse advances the counter |
| oe_n_i | input | 1 | Active-low output enable |
| pwr_good_i | input | 1 | Active-low power-loss indication (high = power good) |
| addr_o | output | 6 | Inverted selected address; 'z' when disabled |
| drive_en_o | output | 6 | Per-bit drive enable, high when that line is driven |

## Verification
The hardest situation to reach from the ports is the counter's path through its wrap and its power-loss reload. The counter can only be seen through the refresh source, and it moves only through synchronized strobe pulses. The stimulus therefore starts from the reset value of 63, so the first pulse crosses the wrap at once. Pulses of random low width are then interleaved with random select and address patterns. Some pulses are issued while refresh is deselected or power-good is low, and the counter is read back afterwards through the refresh source.

// File: rtl/dram_amux_pkg.sv
`timescale 1ns/1ps
package dram_amux_pkg;
  typedef enum logic [1:0] {
    SRC_COL = 2'd0,
    SRC_ROW = 2'd1,
    SRC_REF = 2'd2
  } src_sel_e;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= strobe_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], strobe_n_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[STAGES-1];
  end

  // end of the low pulse: synchronized strobe just returned high
  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/refresh_ctr.sv
`timescale 1ns/1ps
module refresh_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_good_i,
  input  logic         step_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] ctr_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good_i) ctr_q <= '1;
    else if (step_i)        ctr_q <= ctr_q + 1'b1;
  end

  assign count_o = ctr_q;

  // R8
  pwr_loss_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> count_o == {W{1'b1}});

  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && step_i) |=> count_o == W'($past(count_o) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !step_i) |=> $stable(count_o));
endmodule

// File: rtl/src_select.sv
`timescale 1ns/1ps
module src_select
  import dram_amux_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [2*W-1:0] addr_i,
  input  logic           refresh_en_i,
  input  logic           row_en_i,
  input  logic [W-1:0]   ctr_i,
  input  logic           enable_i,
  output logic [W-1:0]   addr_o,
  output logic [W-1:0]   drive_en_o
);
  src_sel_e     sel;
  logic [W-1:0] picked;
  logic [W-1:0] inv_val;

  always_comb begin
    if (refresh_en_i)  sel = SRC_REF;
    else if (row_en_i) sel = SRC_ROW;
    else               sel = SRC_COL;
  end

  always_comb begin
    unique case (sel)
      SRC_REF: picked = ctr_i;
      SRC_ROW: picked = addr_i[W-1:0];
      default: picked = addr_i[2*W-1:W];
    endcase
  end

  assign inv_val = ~picked;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign drive_en_o[g] = enable_i;
    assign addr_o[g]     = enable_i ? inv_val[g] : 1'bz;
  end
endmodule

// File: rtl/dram_addr_mux.sv
`timescale 1ns/1ps
module dram_addr_mux #(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                refresh_en_i,
  input  logic                row_en_i,
  input  logic                count_n_i,
  input  logic                oe_n_i,
  input  logic                pwr_good_i,
  output logic [ADDR_W/2-1:0] addr_o,
  output logic [ADDR_W/2-1:0] drive_en_o
);
  localparam int HALF_W = ADDR_W / 2;

  logic              step;
  logic [HALF_W-1:0] ctr;
  logic              out_en;

  assign out_en = !oe_n_i && pwr_good_i;

  strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst        (rst),
    .strobe_n_i (count_n_i),
    .rise_o     (step)
  );

  refresh_ctr #(.W(HALF_W)) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good_i),
    .step_i     (step),
    .count_o    (ctr)
  );

  src_select #(.W(HALF_W)) sel_i (
    .addr_i       (addr_i),
    .refresh_en_i (refresh_en_i),
    .row_en_i     (row_en_i),
    .ctr_i        (ctr),
    .enable_i     (out_en),
    .addr_o       (addr_o),
    .drive_en_o   (drive_en_o)
  );

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_n_i || !pwr_good_i) |-> drive_en_o == '0);

  // R3
  refresh_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_i && pwr_good_i && refresh_en_i) |-> addr_o == ~ctr);

  // R1
  row_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_i && pwr_good_i && !refresh_en_i && row_en_i)
      |-> addr_o == ~addr_i[HALF_W-1:0]);

  // R2
  col_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_i && pwr_good_i && !refresh_en_i && !row_en_i)
      |-> addr_o == ~addr_i[ADDR_W-1:HALF_W]);
endmodule

// File: tb/dram_addr_mux_tb_top.sv
`timescale 1ns/1ps
module dram_addr_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr_i;
  logic        refresh_en_i, row_en_i, count_n_i, oe_n_i, pwr_good_i;
  logic [5:0]  addr_o, drive_en_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [5:0] ctr_m;

  always #2 clk = ~clk;

  dram_addr_mux dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .refresh_en_i(refresh_en_i),
    .row_en_i(row_en_i), .count_n_i(count_n_i), .oe_n_i(oe_n_i),
    .pwr_good_i(pwr_good_i), .addr_o(addr_o), .drive_en_o(drive_en_o)
  );

  function automatic logic [5:0] exp_out(input logic [11:0] a, input logic rf,
                                         input logic rw, input logic [5:0] c);
    if (rf)      return ~c;
    else if (rw) return ~a[5:0];
    else         return ~a[11:6];
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    #1;
    chk(req, drive_en_o, 6'h3f);
    chk(req, addr_o, exp_out(addr_i, refresh_en_i, row_en_i, ctr_m));
  endtask

  task automatic pulse(input int low_len);
    @(negedge clk); count_n_i = 1'b0;
    repeat (low_len) @(negedge clk);
    count_n_i = 1'b1;
    repeat (4) @(negedge clk);
    if (pwr_good_i) ctr_m = ctr_m + 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    rst = 1'b1; addr_i = '0; refresh_en_i = 1'b1; row_en_i = 1'b0;
    count_n_i = 1'b1; oe_n_i = 1'b0; pwr_good_i = 1'b1;
    ctr_m = 6'h3f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset value all ones, seen inverted as 0
    chk_out("R9");

    // R1 row half, R2 column half, R4 combinational inversion
    @(negedge clk);
    refresh_en_i = 1'b0; row_en_i = 1'b1; addr_i = 12'hA5C;
    chk_out("R1");
    row_en_i = 1'b0;
    chk_out("R2");
    addr_i = 12'h03F;
    chk_out("R4");
    addr_i = 12'hFC0; row_en_i = 1'b1;
    chk_out("R4");

    // R3 refresh wins regardless of row select and address
    refresh_en_i = 1'b1; row_en_i = 1'b1; addr_i = 12'h123;
    chk_out("R3");
    row_en_i = 1'b0; addr_i = 12'hEDC;
    chk_out("R3");

    // R6 wrap 63 -> 0 on first pulse
    pulse(2);
    chk_out("R6");
    chk("R6", ctr_m, 6'h00);

    // R5 held low: no step until release
    @(negedge clk); count_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk_out("R5");
    count_n_i = 1'b1;
    repeat (4) @(negedge clk);
    ctr_m = ctr_m + 1'b1;
    chk_out("R5");

    // R6 counts while refresh deselected
    refresh_en_i = 1'b0;
    pulse(1);
    pulse(3);
    refresh_en_i = 1'b1;
    chk_out("R6");

    // random mix
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      addr_i       = 12'($urandom);
      refresh_en_i = 1'($urandom);
      row_en_i     = 1'($urandom);
      if (($urandom % 4) == 0) pulse(1 + int'($urandom % 4));
      chk_out("R3");
    end

    // R7 output enable off
    @(negedge clk); oe_n_i = 1'b1;
    #1 chk("R7", drive_en_o, 6'h00);
    addr_i = 12'h5A5; refresh_en_i = 1'b0;
    #1 chk("R7", drive_en_o, 6'h00);
    @(negedge clk); oe_n_i = 1'b0; refresh_en_i = 1'b1;
    chk_out("R7");

    // R8 power loss: disabled, pulses ignored, counter back to 63
    pulse(2);
    @(negedge clk); pwr_good_i = 1'b0;
    #1 chk("R8", drive_en_o, 6'h00);
    pulse(2);
    @(negedge clk); pwr_good_i = 1'b1; ctr_m = 6'h3f;
    chk_out("R8");
    pulse(1);
    chk_out("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule